// File: doc/BRIEF.md
# Parallel Multi-Row Queen Placement Checker

This block decides, in a single evaluation, where the next queen of an N-queens backtracking search may go. It takes the rows of the queens already placed, the index of the column being filled, a starting row and the board size N. It then tests a window of K consecutive candidate rows against every placed queen at once. The search controller steps the starting row and the column and keeps the board; this block only answers the question "which row in this window is free?".

Every candidate lane compares its row against all earlier columns in parallel, looking for a shared row, a shared falling diagonal or a shared rising diagonal. A priority encoder then takes the lowest legal lane. The answer is registered into a verdict state one clock after the inputs are sampled. The verdict has four states. V_IDLE holds after reset. V_PLACE means a legal row was found. V_ADVANCE means no row in the window is free but the board has rows past the window, so the controller moves the start up by K. V_BACKTRACK means the window reached or passed the last row and nothing was free. The state register is rewritten on every clock, so any state can follow any state. The next state is V_PLACE if any lane is legal, otherwise V_BACKTRACK if start+K ≥ N, otherwise V_ADVANCE. Reset forces V_IDLE.

Rows and columns are numbered from 0. Column i of the placed array sits in bits [i*RW +: RW] of the flat board input, where RW = $clog2(MAX_N).

Top module: `nq_window_check`

## Requirements
- R1: While reset is asserted and after it, until the first evaluation, found, exhausted and pick_row are all 0 (state V_IDLE).
- R2: The outputs reflect the inputs sampled at the previous rising clock edge (one cycle of latency).
- R3: A candidate row r in column c is illegal if any placed column i < c holds a queen in row r.
- R4: A candidate row r is illegal if a placed queen (i, b) has r − c = b − i (falling diagonal).
- R5: A candidate row r is illegal if a placed queen (i, b) has r + c = b + i (rising diagonal).
- R6: Array entries for columns i ≥ c are ignored; with c = 0 the first in-range candidate is always legal.
- R7: The candidates are rows start, start+1, …, start+K−1; any candidate ≥ N is illegal.
- R8: When any candidate is legal, found = 1 and pick_row is the lowest legal candidate row.
- R9: When no candidate is legal and start+K ≥ N, exhausted = 1, found = 0 and pick_row = 0.
- R10: When no candidate is legal and start+K < N, found = 0, exhausted = 0 and pick_row = 0.
- R11: found and exhausted are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| board_flat | input | MAX_N*RW | Row of the queen in each column, column i at bits [i*RW +: RW] |
| col | input | RW | Column being filled; columns below it count as placed |
| start_row | input | RW | First candidate row of the window |
| size_n | input | $clog2(MAX_N+1) | Board size N |
| found | output | 1 | A legal candidate exists (V_PLACE) |
| pick_row | output | RW | Lowest legal candidate row, 0 when none |
| exhausted | output | 1 | Window reached past the last row with no legal candidate (V_BACKTRACK) |

## Verification
The bench goes after each conflict kind on its own: same row, falling diagonal and rising diagonal. A design that dropped or mis-signed one diagonal would report a row that is under attack. It fills the columns at and above c with rows that clash, so a checker that failed to mask unplaced columns would reject free rows. It places windows that straddle row N, where a missing bound check would pick an off-board row and a wrong boundary would swap advance and backtrack. Windows holding several legal rows catch an encoder that favours the highest lane. Random placements, compared with a brute-force model on every clock, cover the remaining mixtures.

// File: rtl/nq_pkg.sv
package nq_pkg;
    typedef enum logic [1:0] {
        V_IDLE      = 2'd0,
        V_PLACE     = 2'd1,
        V_ADVANCE   = 2'd2,
        V_BACKTRACK = 2'd3
    } verdict_t;
endpackage

// File: rtl/nq_lane.sv
// One candidate row compared against every placed column in parallel.
module nq_lane #(
    parameter int MAX_N = 8,
    parameter int RW    = 3,
    parameter int NW    = 4,
    parameter int EW    = 5
) (
    input  logic [MAX_N*RW-1:0] board_flat,
    input  logic [RW-1:0]       col,
    input  logic [EW-1:0]       cand,
    input  logic [NW-1:0]       size_n,
    output logic                legal
);
    localparam int SW = EW + 2;

    logic [MAX_N-1:0] hit;
    logic [SW-1:0]    rr;
    logic [SW-1:0]    cc;

    assign rr = SW'(cand);
    assign cc = SW'(col);

    for (genvar i = 0; i < MAX_N; i++) begin : g_col
        logic [SW-1:0] bb;
        logic [SW-1:0] ii;
        logic          placed;
        logic          same_row;
        logic          fall_diag;
        logic          rise_diag;
        assign bb        = SW'(board_flat[i*RW +: RW]);
        assign ii        = SW'(i);
        assign placed    = ii < cc;
        assign same_row  = bb == rr;
        assign fall_diag = (rr + ii) == (bb + cc);
        assign rise_diag = (rr + cc) == (bb + ii);
        assign hit[i]    = placed && (same_row || fall_diag || rise_diag);
    end

    assign legal = (rr < SW'(size_n)) && (hit == '0);
endmodule

// File: rtl/nq_prio.sv
// Lowest-index-first priority encoder over the lane results.
module nq_prio #(
    parameter int K  = 2,
    parameter int IW = 1
) (
    input  logic [K-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int j = K - 1; j >= 0; j--) begin
            if (req[j]) begin
                any = 1'b1;
                idx = IW'(j);
            end
        end
    end
endmodule

// File: rtl/nq_window_check.sv
module nq_window_check
    import nq_pkg::*;
#(
    parameter int MAX_N = 8,
    parameter int K     = 2,
    parameter int RW    = (MAX_N > 1) ? $clog2(MAX_N) : 1,
    parameter int NW    = $clog2(MAX_N + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MAX_N*RW-1:0] board_flat,
    input  logic [RW-1:0]       col,
    input  logic [RW-1:0]       start_row,
    input  logic [NW-1:0]       size_n,
    output logic                found,
    output logic [RW-1:0]       pick_row,
    output logic                exhausted
);
    localparam int EW = $clog2(MAX_N + K) + 1;
    localparam int IW = (K > 1) ? $clog2(K) : 1;

    logic [K-1:0]  lane_ok;
    logic          any_ok;
    logic [IW-1:0] win_idx;
    logic [EW-1:0] win_end;
    verdict_t      state_q;
    verdict_t      state_d;
    logic [RW-1:0] row_q;
    logic [RW-1:0] row_d;

    for (genvar j = 0; j < K; j++) begin : g_lane
        logic [EW-1:0] cand;
        assign cand = EW'(start_row) + EW'(j);
        nq_lane #(.MAX_N(MAX_N), .RW(RW), .NW(NW), .EW(EW)) u_lane (
            .board_flat (board_flat),
            .col        (col),
            .cand       (cand),
            .size_n     (size_n),
            .legal      (lane_ok[j])
        );
    end

    nq_prio #(.K(K), .IW(IW)) u_prio (
        .req (lane_ok),
        .any (any_ok),
        .idx (win_idx)
    );

    assign win_end = EW'(start_row) + EW'(K);

    always_comb begin
        row_d = '0;
        if (any_ok) begin
            state_d = V_PLACE;
            row_d   = RW'(EW'(start_row) + EW'(win_idx));
        end else if (win_end >= EW'(size_n)) begin
            state_d = V_BACKTRACK;
        end else begin
            state_d = V_ADVANCE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= V_IDLE;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
        end
    end

    always_comb begin
        found     = 1'b0;
        exhausted = 1'b0;
        pick_row  = '0;
        unique case (state_q)
            V_IDLE:      ;
            V_PLACE: begin
                found    = 1'b1;
                pick_row = row_q;
            end
            V_ADVANCE:   ;
            V_BACKTRACK: exhausted = 1'b1;
        endcase
    end

    // R11: the two verdict flags exclude each other
    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && exhausted));

    // R7: a picked row lies inside the window and on the board
    a_r7_pick_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && found) |->
            (EW'(pick_row) >= EW'($past(start_row))) &&
            (EW'(pick_row) < EW'($past(start_row)) + EW'(K)) &&
            (EW'(pick_row) < EW'($past(size_n))));

    // R9: backtrack only when the window reached the last row
    a_r9_backtrack_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && exhausted) |->
            (EW'($past(start_row)) + EW'(K) >= EW'($past(size_n))));

    // R6: first column has nothing placed, so an on-board start row wins
    a_r6_first_column_free: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(col) == '0 &&
         EW'($past(start_row)) < EW'($past(size_n))) |->
            (found && pick_row == $past(start_row)));
endmodule

// File: tb/nq_window_check_test.sv
`timescale 1ns/1ps
module nq_window_check_test;
    localparam int MAX_N = 8;
    localparam int K     = 3;
    localparam int RW    = 3;
    localparam int NW    = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [MAX_N*RW-1:0] board_flat = '0;
    logic [RW-1:0]       col = '0;
    logic [RW-1:0]       start_row = '0;
    logic [NW-1:0]       size_n = NW'(8);
    logic                found;
    logic [RW-1:0]       pick_row;
    logic                exhausted;

    int total = 0;
    int bad   = 0;
    int board_m [MAX_N];

    always #10 clk = ~clk;

    nq_window_check #(.MAX_N(MAX_N), .K(K)) uut (
        .clk(clk), .rst_n(rst_n), .board_flat(board_flat), .col(col),
        .start_row(start_row), .size_n(size_n),
        .found(found), .pick_row(pick_row), .exhausted(exhausted)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // brute-force reference
    task automatic model(input int c, input int s, input int n,
                         output int e_found, output int e_row, output int e_exh);
        e_found = 0; e_row = 0; e_exh = 0;
        for (int j = 0; j < K; j++) begin
            int r = s + j;
            int ok = (r < n) ? 1 : 0;
            for (int i = 0; i < c; i++) begin
                if (board_m[i] == r || board_m[i] - i == r - c || board_m[i] + i == r + c) ok = 0;
            end
            if (ok == 1 && e_found == 0) begin
                e_found = 1;
                e_row   = r;
            end
        end
        if (e_found == 0 && s + K >= n) e_exh = 1;
    endtask

    task automatic apply(input string tag, input int c, input int s, input int n);
        int ef, er, ee;
        @(negedge clk);
        for (int i = 0; i < MAX_N; i++) board_flat[i*RW +: RW] = RW'(board_m[i]);
        col = RW'(c); start_row = RW'(s); size_n = NW'(n);
        model(c, s, n, ef, er, ee);
        @(posedge clk);
        @(negedge clk);
        check(tag, int'(found), ef, "found");
        check(tag, int'(pick_row), er, "pick_row");
        check(tag, int'(exhausted), ee, "exhausted");
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < MAX_N; i++) board_m[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", int'(found), 0, "found");
        check("R1", int'(pick_row), 0, "pick_row");
        check("R1", int'(exhausted), 0, "exhausted");
        rst_n = 1'b1;

        // R3: row 2 taken by column 0, start window at 2 with col 1
        board_m[0] = 2;
        apply("R3", 1, 2, 8);          // 2 same row, 3 falling diag, 4 free
        // R4: falling diagonal only: queen (0,0), col 2, row 2 attacked
        board_m[0] = 0; board_m[1] = 5;
        apply("R4", 2, 2, 8);          // 2 diag hit, 3 attacked by (1,5)? no; expect 3
        // R5: rising diagonal: queen (0,4), col 2, row 2 attacked
        board_m[0] = 4; board_m[1] = 7;
        apply("R5", 2, 2, 8);
        // R6: columns at and above c hold clashing junk, must be ignored
        for (int i = 0; i < MAX_N; i++) board_m[i] = 3;
        apply("R6", 0, 3, 8);
        board_m[0] = 0;
        apply("R6", 1, 3, 8);          // columns 1.. ignored, row 3 free from (0,0)
        // R7: window straddling N, only off-board rows left
        board_m[0] = 3;
        apply("R7", 1, 3, 5);          // 3 row, 4 diag, 5 off board -> backtrack
        // R8/R10: four queens placed (0,2,4,1), fifth column
        board_m[0] = 0; board_m[1] = 2; board_m[2] = 4; board_m[3] = 1;
        apply("R10", 4, 0, 5);         // rows 0..2 all busy, window inside board
        apply("R8", 4, 3, 5);          // row 3 is the solution
        // R8: several legal rows, lowest wins
        board_m[0] = 7;
        apply("R8", 1, 0, 8);
        // R9: empty window at the board edge
        board_m[0] = 2;
        apply("R9", 1, 2, 4);          // 2 row, 3 diag -> backtrack
        // R2: output follows the previous edge's inputs, hold values steady
        apply("R2", 0, 0, 8);
        apply("R2", 0, 7, 8);
        // R11 and general mixtures: random placements vs model
        for (int t = 0; t < 400; t++) begin
            int n = 4 + ($urandom % 5);
            int c = $urandom % n;
            int s = $urandom % n;
            for (int i = 0; i < MAX_N; i++) board_m[i] = $urandom % n;
            apply("R11", c, s, n);
        end
        // R1: reset again returns to idle
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1", int'(found), 0, "found");
        check("R1", int'(exhausted), 0, "exhausted");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule